// File: doc/BRIEF.md
# Shared-Storage Multi-Channel Command Queue with Inspection Port

This block keeps several independent command-word queues in one storage array. Each channel owns a window of that array, given by a first-word address and a last-word address, and runs a circular queue inside it. A producer writes words into a channel through the push port. A consumer takes words out through the pop port and receives each one on the cycle after its pop. Each channel reports whether it is empty or full. Each channel also has sticky flags that record a push to a full queue and a pop from an empty one.

An inspection port lets a host choose one channel and observe its read and write positions. Through the same port the host can read any storage word by its absolute address. Inspection only reads state, so it can run while the queues are in normal use. Software can move a channel's window at any time by writing its setup. Writing the setup discards everything the channel holds.

Top module: `cmdq_multi_fifo`

## Requirements
- R1: After reset every channel is empty and not full, and all overflow and underflow flags are clear. Channel c owns addresses c*DEPTH/NCH through c*DEPTH/NCH+DEPTH/NCH-1. Inspection is off, so its pointer and data outputs read zero, and `pop_valid` is low.
- R2: Words leave a channel in the order they entered it. An accepted pop drives the oldest word on `pop_word` with `pop_valid` high on the cycle right after the pop.
- R3: A channel is empty when its read position equals its write position. It is full when advancing the write position would make it equal the read position, so a window from address b to address l holds l-b words.
- R4: After an accepted push, the write position moves to the window's first address if it was at the last address, and to the next address otherwise. The read position follows the same rule after an accepted pop.
- R5: A setup write loads the channel's first and last addresses and puts both of its positions at the new first address. A push or pop to that channel in the same cycle is dropped and sets no flag.
- R6: A push to a full channel stores nothing and sets that channel's overflow flag. A pop from an empty channel returns nothing (`pop_valid` stays low) and sets its underflow flag. Both flags stay set until reset.
- R7: Activity on one channel changes no other channel's positions, flags or stored words.
- R8: An inspection control write loads an on bit, a channel number and an address. From the next cycle, while the on bit is set, `peek_rd_ptr` and `peek_wr_ptr` show the chosen channel's current read and write positions. While it is clear they show zero.
- R9: While inspection is on, `peek_word` holds the storage word at the inspection address. The word is valid on the cycle after the control write and is refreshed every cycle afterward. Inspection never changes any position, flag or stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| setup_we | input | 1 | Setup write strobe |
| setup_chan | input | CW | Channel whose window is written |
| setup_base | input | AW | First address of the window |
| setup_limit | input | AW | Last address of the window |
| push_en | input | 1 | Push request |
| push_chan | input | CW | Channel pushed to |
| push_word | input | DW | Word pushed |
| pop_en | input | 1 | Pop request |
| pop_chan | input | CW | Channel popped from |
| pop_word | output | DW | Popped word, one cycle after the pop |
| pop_valid | output | 1 | High when `pop_word` holds a popped word |
| chan_empty | output | NCH | Per-channel empty flag |
| chan_full | output | NCH | Per-channel full flag |
| chan_ovf | output | NCH | Per-channel sticky overflow flag |
| chan_unf | output | NCH | Per-channel sticky underflow flag |
| peek_we | input | 1 | Inspection control write strobe |
| peek_on | input | 1 | Inspection enable value written |
| peek_sel | input | CW | Inspected channel written |
| peek_addr | input | AW | Inspected storage address written |
| peek_rd_ptr | output | AW | Read position of inspected channel, zero when off |
| peek_wr_ptr | output | AW | Write position of inspected channel, zero when off |
| peek_word | output | DW | Storage word at inspected address, zero when off |

## Verification
The bench builds the block with four channels, 64 words of storage and 32-bit words, which gives each channel a 16-word default window. With windows that small, a few dozen pushes reach the full condition, the wrap from the last address back to the first, and the overflow and underflow flags. Random reprogramming inside each channel's default range produces single-word windows (always full and empty at once) and short windows of two or three words. These come up many times in a run of a few thousand cycles.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

   // Elaboration helpers shared by the queue modules
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // Default window of a channel: equal slices of the storage
   function automatic int slice_first(input int chan, input int depth, input int nch);
      return chan * (depth / nch);
   endfunction

   function automatic int slice_last(input int chan, input int depth, input int nch);
      return chan * (depth / nch) + (depth / nch) - 1;
   endfunction

endpackage

// File: rtl/cmdq_chan_ptrs.sv
module cmdq_chan_ptrs #(
   parameter int AW        = 6,
   parameter int RST_FIRST = 0,
   parameter int RST_LAST  = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_hit,
   input  logic [AW-1:0] cfg_first,
   input  logic [AW-1:0] cfg_last,
   input  logic          push_hit,
   input  logic          pop_hit,
   output logic [AW-1:0] rd_pos,
   output logic [AW-1:0] wr_pos,
   output logic          is_empty,
   output logic          is_full,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          ovf,
   output logic          unf
);

   localparam logic [AW-1:0] FIRST0 = AW'(RST_FIRST);
   localparam logic [AW-1:0] LAST0  = AW'(RST_LAST);

   logic [AW-1:0] first_q, last_q;
   logic [AW-1:0] wr_next, rd_next;

   // advance with wrap at the window end
   function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                          input logic [AW-1:0] f,
                                          input logic [AW-1:0] l);
      return (p == l) ? f : p + 1'b1;
   endfunction

   always_comb begin
      wr_next  = step(wr_pos, first_q, last_q);
      rd_next  = step(rd_pos, first_q, last_q);
      is_empty = (rd_pos == wr_pos);
      is_full  = (wr_next == rd_pos);
      push_ok  = push_hit && !is_full && !cfg_hit;
      pop_ok   = pop_hit && !is_empty && !cfg_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= FIRST0;
         last_q  <= LAST0;
         rd_pos  <= FIRST0;
         wr_pos  <= FIRST0;
         ovf     <= 1'b0;
         unf     <= 1'b0;
      end else if (cfg_hit) begin
         first_q <= cfg_first;
         last_q  <= cfg_last;
         rd_pos  <= cfg_first;
         wr_pos  <= cfg_first;
      end else begin
         if (push_ok) wr_pos <= wr_next;
         if (pop_ok)  rd_pos <= rd_next;
         if (push_hit && is_full)  ovf <= 1'b1;
         if (pop_hit && is_empty)  unf <= 1'b1;
      end
   end

   // R4: wrap from the last address back to the first
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && wr_pos == last_q) |=> (wr_pos == $past(first_q)));

   // R4: plain increment away from the window end
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && rd_pos != last_q) |=> (rd_pos == $past(rd_pos) + 1'b1));

   // R5: setup puts both positions on the new first address
   p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |=> (rd_pos == $past(cfg_first)) && (wr_pos == $past(cfg_first)));

   // R6: rejected push leaves the write position and flags it
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_hit && is_full && !cfg_hit) |=> ($stable(wr_pos) && ovf));

   // R6: rejected pop leaves the read position and flags it
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_hit && is_empty && !cfg_hit) |=> ($stable(rd_pos) && unf));

   // R6: flags are sticky
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf || unf) |=> ($past(ovf) -> ovf) && ($past(unf) -> unf));

endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
   parameter int DEPTH     = 64,
   parameter int DW        = 32,
   parameter bit MEM_CLEAR = 1'b1,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   input  logic          insp_en,
   input  logic [AW-1:0] insp_addr,
   output logic [DW-1:0] insp_data
);

   logic [DW-1:0] mem [DEPTH];

   generate
      if (MEM_CLEAR) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_addr] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         rd_valid  <= 1'b0;
         insp_data <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= mem[rd_addr];
         insp_data <= insp_en ? mem[insp_addr] : '0;
      end
   end

   // R2: popped word appears on the following cycle
   p_pop_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R9: inspection output is zero while inspection is off
   p_insp_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !insp_en |=> (insp_data == '0));

endmodule

// File: rtl/cmdq_peek.sv
module cmdq_peek #(
   parameter int NCH = 4,
   parameter int AW  = 6,
   localparam int CW = $clog2(NCH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic          ctl_on,
   input  logic [CW-1:0] ctl_sel,
   input  logic [AW-1:0] ctl_addr,
   input  logic [AW-1:0] rd_pos [NCH],
   input  logic [AW-1:0] wr_pos [NCH],
   output logic [AW-1:0] sel_rd,
   output logic [AW-1:0] sel_wr,
   output logic          mem_en,
   output logic [AW-1:0] mem_addr
);

   logic          on_q;
   logic [CW-1:0] sel_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         sel_q  <= '0;
         addr_q <= '0;
      end else if (ctl_we) begin
         on_q   <= ctl_on;
         sel_q  <= ctl_sel;
         addr_q <= ctl_addr;
      end
   end

   // storage read follows the control value being written this cycle
   always_comb begin
      mem_en   = ctl_we ? ctl_on : on_q;
      mem_addr = ctl_we ? ctl_addr : addr_q;
      sel_rd   = on_q ? rd_pos[sel_q] : '0;
      sel_wr   = on_q ? wr_pos[sel_q] : '0;
   end

   // R8: switching inspection off clears the pointer view
   p_off_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !ctl_on) |=> (sel_rd == '0) && (sel_wr == '0));

endmodule

// File: rtl/cmdq_multi_fifo.sv
module cmdq_multi_fifo #(
   parameter int NCH       = 4,
   parameter int DEPTH     = 64,
   parameter int DW        = 32,
   parameter bit MEM_CLEAR = 1'b1,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           setup_we,
   input  logic [CW-1:0]  setup_chan,
   input  logic [AW-1:0]  setup_base,
   input  logic [AW-1:0]  setup_limit,
   input  logic           push_en,
   input  logic [CW-1:0]  push_chan,
   input  logic [DW-1:0]  push_word,
   input  logic           pop_en,
   input  logic [CW-1:0]  pop_chan,
   output logic [DW-1:0]  pop_word,
   output logic           pop_valid,
   output logic [NCH-1:0] chan_empty,
   output logic [NCH-1:0] chan_full,
   output logic [NCH-1:0] chan_ovf,
   output logic [NCH-1:0] chan_unf,
   input  logic           peek_we,
   input  logic           peek_on,
   input  logic [CW-1:0]  peek_sel,
   input  logic [AW-1:0]  peek_addr,
   output logic [AW-1:0]  peek_rd_ptr,
   output logic [AW-1:0]  peek_wr_ptr,
   output logic [DW-1:0]  peek_word
);

   import cmdq_pkg::*;

   // elaboration-time parameter checks
   generate
      if (NCH < 2 || !is_pow2(NCH)) begin : g_bad_nch
         $error("NCH must be a power of two of at least 2");
      end
      if (!is_pow2(DEPTH) || DEPTH < 2 * NCH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2*NCH");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic [AW-1:0]  rd_pos_a [NCH];
   logic [AW-1:0]  wr_pos_a [NCH];
   logic [NCH-1:0] push_ok_v, pop_ok_v;
   logic           insp_en;
   logic [AW-1:0]  insp_addr;

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_chan
         cmdq_chan_ptrs #(
            .AW        (AW),
            .RST_FIRST (slice_first(c, DEPTH, NCH)),
            .RST_LAST  (slice_last(c, DEPTH, NCH))
         ) u_ptrs (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_hit   (setup_we && (setup_chan == CW'(c))),
            .cfg_first (setup_base),
            .cfg_last  (setup_limit),
            .push_hit  (push_en && (push_chan == CW'(c))),
            .pop_hit   (pop_en && (pop_chan == CW'(c))),
            .rd_pos    (rd_pos_a[c]),
            .wr_pos    (wr_pos_a[c]),
            .is_empty  (chan_empty[c]),
            .is_full   (chan_full[c]),
            .push_ok   (push_ok_v[c]),
            .pop_ok    (pop_ok_v[c]),
            .ovf       (chan_ovf[c]),
            .unf       (chan_unf[c])
         );
      end
   endgenerate

   cmdq_store #(
      .DEPTH     (DEPTH),
      .DW        (DW),
      .MEM_CLEAR (MEM_CLEAR)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (|push_ok_v),
      .wr_addr   (wr_pos_a[push_chan]),
      .wr_data   (push_word),
      .rd_en     (|pop_ok_v),
      .rd_addr   (rd_pos_a[pop_chan]),
      .rd_data   (pop_word),
      .rd_valid  (pop_valid),
      .insp_en   (insp_en),
      .insp_addr (insp_addr),
      .insp_data (peek_word)
   );

   cmdq_peek #(
      .NCH (NCH),
      .AW  (AW)
   ) u_peek (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (peek_we),
      .ctl_on   (peek_on),
      .ctl_sel  (peek_sel),
      .ctl_addr (peek_addr),
      .rd_pos   (rd_pos_a),
      .wr_pos   (wr_pos_a),
      .sel_rd   (peek_rd_ptr),
      .sel_wr   (peek_wr_ptr),
      .mem_en   (insp_en),
      .mem_addr (insp_addr)
   );

   // R7: at most one channel accepts a push and one a pop per cycle
   p_one_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(push_ok_v) && $onehot0(pop_ok_v));

   // R6: a rejected pop produces no popped word
   p_no_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && pop_ok_v == '0) |=> !pop_valid);

endmodule

// File: tb/sim_cmdq_multi_fifo.sv
module sim_cmdq_multi_fifo;

   localparam int NCH = 4, DEPTH = 64, DW = 32, AW = 6, CW = 2, SEG = DEPTH / NCH;

   logic clk = 1'b0, rst_n = 1'b0;
   logic setup_we = 0, push_en = 0, pop_en = 0, peek_we = 0, peek_on = 0;
   logic [CW-1:0] setup_chan = 0, push_chan = 0, pop_chan = 0, peek_sel = 0;
   logic [AW-1:0] setup_base = 0, setup_limit = 0, peek_addr = 0;
   logic [DW-1:0] push_word = 0;
   logic [DW-1:0] pop_word, peek_word;
   logic pop_valid;
   logic [NCH-1:0] chan_empty, chan_full, chan_ovf, chan_unf;
   logic [AW-1:0] peek_rd_ptr, peek_wr_ptr;

   always #4 clk = ~clk;

   cmdq_multi_fifo #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .setup_we(setup_we), .setup_chan(setup_chan),
      .setup_base(setup_base), .setup_limit(setup_limit), .push_en(push_en),
      .push_chan(push_chan), .push_word(push_word), .pop_en(pop_en),
      .pop_chan(pop_chan), .pop_word(pop_word), .pop_valid(pop_valid),
      .chan_empty(chan_empty), .chan_full(chan_full), .chan_ovf(chan_ovf),
      .chan_unf(chan_unf), .peek_we(peek_we), .peek_on(peek_on),
      .peek_sel(peek_sel), .peek_addr(peek_addr), .peek_rd_ptr(peek_rd_ptr),
      .peek_wr_ptr(peek_wr_ptr), .peek_word(peek_word));

   int total = 0, bad = 0;
   bit finished = 0;

   // reference model
   int mb[NCH], ml[NCH], mr[NCH], mw[NCH];
   bit movf[NCH], munf[NCH];
   logic [DW-1:0] mm[DEPTH];
   bit peek_is_on = 0;
   int peek_c = 0, peek_a = 0;

   function automatic int nx(int c, int p);
      return (p == ml[c]) ? mb[c] : p + 1;
   endfunction
   function automatic bit m_empty(int c);
      return mr[c] == mw[c];
   endfunction
   function automatic bit m_full(int c);
      return nx(c, mw[c]) == mr[c];
   endfunction

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_flags(string req);
      logic [NCH-1:0] e, f, o, u;
      for (int c = 0; c < NCH; c++) begin
         e[c] = m_empty(c); f[c] = m_full(c); o[c] = movf[c]; u[c] = munf[c];
      end
      chk(chan_empty === e, req, "empty", 64'(chan_empty), 64'(e));
      chk(chan_full === f, req, "full", 64'(chan_full), 64'(f));
      chk(chan_ovf === o, req, "ovf", 64'(chan_ovf), 64'(o));
      chk(chan_unf === u, req, "unf", 64'(chan_unf), 64'(u));
   endtask

   // one cycle of queue traffic, checked against the model
   task automatic cyc(bit pu, int pc, logic [DW-1:0] pd, bit po, int oc,
                      bit cf, int cc, int cb, int cl, string req);
      bit push_acc, pop_acc;
      logic [DW-1:0] exp_d;
      @(negedge clk);
      peek_we = 0;
      push_en = pu; push_chan = CW'(pc); push_word = pd;
      pop_en = po; pop_chan = CW'(oc);
      setup_we = cf; setup_chan = CW'(cc); setup_base = AW'(cb); setup_limit = AW'(cl);
      push_acc = pu && !(cf && cc == pc) && !m_full(pc);
      pop_acc  = po && !(cf && cc == oc) && !m_empty(oc);
      if (pu && !(cf && cc == pc) && m_full(pc)) movf[pc] = 1;
      if (po && !(cf && cc == oc) && m_empty(oc)) munf[oc] = 1;
      exp_d = pop_acc ? mm[mr[oc]] : '0;
      if (push_acc) begin mm[mw[pc]] = pd; mw[pc] = nx(pc, mw[pc]); end
      if (pop_acc) mr[oc] = nx(oc, mr[oc]);
      if (cf) begin mb[cc] = cb; ml[cc] = cl; mr[cc] = cb; mw[cc] = cb; end
      @(posedge clk);
      #1;
      chk(pop_valid === pop_acc, req, "pop_valid", 64'(pop_valid), 64'(pop_acc));
      if (pop_acc) chk(pop_word === exp_d, req, "pop_word", 64'(pop_word), 64'(exp_d));
      chk_flags(req);
   endtask

   task automatic idle(string req);
      cyc(0, 0, '0, 0, 0, 0, 0, 0, 0, req);
   endtask

   task automatic peek(bit on, int c, int a, string req);
      logic [AW-1:0] er, ew;
      logic [DW-1:0] ed;
      @(negedge clk);
      push_en = 0; pop_en = 0; setup_we = 0;
      peek_we = 1; peek_on = on; peek_sel = CW'(c); peek_addr = AW'(a);
      peek_is_on = on; peek_c = c; peek_a = a;
      @(posedge clk);
      #1;
      er = on ? AW'(mr[c]) : '0;
      ew = on ? AW'(mw[c]) : '0;
      ed = on ? mm[a] : '0;
      chk(peek_rd_ptr === er, req, "peek_rd_ptr", 64'(peek_rd_ptr), 64'(er));
      chk(peek_wr_ptr === ew, req, "peek_wr_ptr", 64'(peek_wr_ptr), 64'(ew));
      chk(peek_word === ed, req, "peek_word", 64'(peek_word), 64'(ed));
      chk_flags("R9");
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] w;
      void'($urandom(32'h1F3A));
      for (int c = 0; c < NCH; c++) begin
         mb[c] = c * SEG; ml[c] = c * SEG + SEG - 1; mr[c] = mb[c]; mw[c] = mb[c];
         movf[c] = 0; munf[c] = 0;
      end
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(chan_empty === '1, "R1", "empty", 64'(chan_empty), 64'hF);
      chk(chan_full === '0, "R1", "full", 64'(chan_full), 0);
      chk((chan_ovf | chan_unf) === '0, "R1", "flags", 64'(chan_ovf | chan_unf), 0);
      chk(pop_valid === 1'b0, "R1", "pop_valid", 64'(pop_valid), 0);
      chk(peek_rd_ptr === '0 && peek_word === '0, "R1", "peek off", 64'(peek_rd_ptr), 0);
      // R1/R8: default window of channel 2
      peek(1, 2, 0, "R8");
      chk(peek_rd_ptr === AW'(32), "R1", "ch2 first", 64'(peek_rd_ptr), 32);
      // R9: refresh after a push into the inspected address
      peek(1, 0, 0, "R9");
      cyc(1, 0, 32'hCAFE_0001, 0, 0, 0, 0, 0, 0, "R9");
      chk(peek_word === '0, "R9", "old word same edge", 64'(peek_word), 0);
      idle("R9");
      chk(peek_word === 32'hCAFE_0001, "R9", "refreshed word", 64'(peek_word), 64'hCAFE_0001);
      // R2/R3/R4: drain, fill to capacity across the wrap, overflow
      cyc(0, 0, '0, 1, 0, 0, 0, 0, 0, "R2");
      for (int i = 0; i < SEG - 1; i++) cyc(1, 0, 32'hA000 + i, 0, 0, 0, 0, 0, 0, "R3");
      chk(chan_full[0] === 1'b1, "R3", "full after 15", 64'(chan_full[0]), 1);
      peek(1, 0, 0, "R4");
      chk(peek_wr_ptr === '0, "R4", "wrapped wr", 64'(peek_wr_ptr), 0);
      cyc(1, 0, 32'hDEAD, 0, 0, 0, 0, 0, 0, "R6");
      chk(chan_ovf[0] === 1'b1, "R6", "ovf set", 64'(chan_ovf[0]), 1);
      for (int i = 0; i < SEG - 1; i++) cyc(0, 0, '0, 1, 0, 0, 0, 0, 0, "R2");
      cyc(0, 0, '0, 1, 0, 0, 0, 0, 0, "R6");
      chk(chan_unf[0] === 1'b1 && pop_valid === 1'b0, "R6", "unf set", 64'(chan_unf[0]), 1);
      chk(chan_ovf[1] === 1'b0, "R7", "ch1 ovf untouched", 64'(chan_ovf[1]), 0);
      // R5: setup with a colliding push, then a three-word window
      cyc(1, 3, 32'hBEEF, 0, 0, 1, 3, 50, 52, "R5");
      chk(chan_ovf[3] === 1'b0, "R5", "no flag on collision", 64'(chan_ovf[3]), 0);
      peek(1, 3, 50, "R5");
      cyc(1, 3, 32'h31, 0, 0, 0, 0, 0, 0, "R5");
      cyc(1, 3, 32'h32, 0, 0, 0, 0, 0, 0, "R5");
      cyc(1, 3, 32'h33, 0, 0, 0, 0, 0, 0, "R6");
      chk(chan_ovf[3] === 1'b1, "R6", "ovf small window", 64'(chan_ovf[3]), 1);
      // random phase with occasional inspection and setup
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom_range(0, 63));
         if (r < 6) begin
            peek(1, int'($urandom_range(0, NCH - 1)), int'($urandom_range(0, DEPTH - 1)), "R8");
         end else if (r == 6) begin
            int c = int'($urandom_range(0, NCH - 1));
            int b = c * SEG + int'($urandom_range(0, SEG - 1));
            int l = b + int'($urandom_range(0, c * SEG + SEG - 1 - b));
            cyc(bit'($urandom_range(0, 1)), c, $urandom, 0, 0, 1, c, b, l, "R5");
         end else begin
            w = $urandom;
            cyc(bit'($urandom_range(0, 1)), int'($urandom_range(0, NCH - 1)), w,
                bit'($urandom_range(0, 1)), int'($urandom_range(0, NCH - 1)),
                0, 0, 0, 0, "R7");
         end
      end
      // R8/R9: switch inspection off
      peek(0, 1, 5, "R8");
      idle("R9");
      chk(peek_word === '0, "R9", "off word", 64'(peek_word), 0);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule